// File: doc/BRIEF.md
# DMA Channel Counter with Autoinitialize

This block keeps the transfer bookkeeping for a set of DMA channels (four by default). Each channel holds a base address, a base word count, a current address and a current word count, all 16 bits wide. When the bus sequencer reports that a transfer finished on the active channel, the block steps that channel's current address up or down and decrements its current count. It also decides whether the service has ended, either through its own terminal count or through an external active-low end request.

When a service ends, the channel either reloads its current registers from its base registers (autoinitialize) or masks itself off. In both cases a per-channel terminal-count status bit is latched. A terminal-count pulse is issued for internal terminal counts. In memory-to-memory mode, channel 0 is the source side and never produces the pulse; channel 1, the destination side, does. Bus cycle timing, arbitration and the data path belong to neighbouring blocks.

Top module: `dma_chan_counter`

## Requirements
- R1: After synchronous reset, every base and current register is 0x0000, the status bits are 0, all mask bits are 1, every mode is up-counting without autoinitialize, and `tc_pulse_o` is low.
- R2: A register write loads both the base and the current register of channel `reg_chan`. The count pair is loaded when `reg_is_count` is 1, and the address pair is loaded when it is 0. The new value is visible on the outputs one cycle later.
- R3: A transfer on the active channel decrements its current count by one. It moves the current address by +1, or by -1 when the channel's `mode_down` bit was written as 1. Both values wrap modulo 2^16.
- R4: Terminal count is a transfer that takes the current count from 0x0000 to 0xFFFF. It raises `tc_pulse_o` for exactly the cycle after the transfer strobe.
- R5: On an end of service for a channel whose autoinitialize bit is 1, the current address and count take the base values instead of stepping, and the channel's mask bit is left unchanged.
- R6: On an end of service without autoinitialize, the channel steps normally, and its mask bit and its status bit (status bit n belongs to channel n) are both set.
- R7: `eop_in_n` low together with a transfer strobe ends the active channel's service exactly as a terminal count would, but it does not raise `tc_pulse_o`.
- R8: With `m2m_en` high, a terminal count on channel 0 raises no pulse, latches no status bit, sets no mask bit and causes no reload; a terminal count on channel 1 behaves as in R4 to R6.
- R9: `status_rd` clears all status bits at the next edge; a status bit set by an end of service in the same cycle stays set.
- R10: A mask write sets or clears only the mask bit of `mask_chan` to `mask_val`; an end of service in the same cycle on that channel takes priority.
- R11: A register write to the active channel in the same cycle as a transfer cancels that transfer: no step, no reload, no pulse, no status or mask change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Base/current register write strobe |
| reg_chan | input | 2 | Channel of the register write |
| reg_is_count | input | 1 | 1 writes the count pair, 0 the address pair |
| reg_wdata | input | 16 | Register write value |
| mode_we | input | 1 | Mode write strobe |
| mode_chan | input | 2 | Channel of the mode write |
| mode_autoinit | input | 1 | Autoinitialize enable to store |
| mode_down | input | 1 | Address decrement select to store |
| m2m_en | input | 1 | Memory-to-memory mode (channel 0 source, channel 1 destination) |
| mask_we | input | 1 | Mask bit write strobe |
| mask_chan | input | 2 | Channel of the mask write |
| mask_val | input | 1 | Mask value to store |
| status_rd | input | 1 | Status read strobe, clears the status bits |
| xfer_done | input | 1 | One transfer finished on the active channel |
| act_chan | input | 2 | Active channel index |
| eop_in_n | input | 1 | External end of service, active low, taken with xfer_done |
| cur_addr_o | output | 16 | Current address of the active channel |
| cur_count_o | output | 16 | Current word count of the active channel |
| tc_pulse_o | output | 1 | One-cycle terminal-count pulse |
| status_o | output | 4 | Terminal-count status bits, bit n for channel n |
| mask_o | output | 4 | Mask bits, bit n for channel n |

## Verification
The bench drives counts of 0 and 1 so that terminal counts fall on the first or second transfer. A design that tests for zero after the decrement instead of before would pulse one transfer early. It combines an end of service with a status read in the same cycle and with a mask clear in the same cycle. A design with the wrong priority would lose a status or mask bit. It runs memory-to-memory with both channels reaching terminal count, which catches a design that pulses or masks on channel 0. It also issues a register write during a transfer on the same channel; a design without the override would step the freshly written value.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
    localparam int NUM_CH   = 4;
    localparam int DATA_W   = 16;
    localparam int CH_W     = $clog2(NUM_CH);

    typedef struct packed {
        logic autoinit;
        logic down;
    } chan_mode_t;

    localparam chan_mode_t MODE_RESET = '{autoinit: 1'b0, down: 1'b0};

    function automatic logic [DATA_W-1:0] addr_step(input logic [DATA_W-1:0] a,
                                                    input logic down);
        return down ? a - DATA_W'(1) : a + DATA_W'(1);
    endfunction
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_addr,
    input  logic              we_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  logic              reload,
    input  logic              down,
    output logic [DATA_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_cnt,
    output logic              wrap
);
    logic [DATA_W-1:0] base_addr, base_cnt;
    logic              wr_any;

    assign wr_any = we_addr | we_cnt;
    assign wrap   = step & ~wr_any & (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (wr_any) begin
            if (we_addr) begin
                base_addr <= wdata;
                cur_addr  <= wdata;
            end
            if (we_cnt) begin
                base_cnt <= wdata;
                cur_cnt  <= wdata;
            end
        end else if (reload) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
        end else if (step) begin
            cur_addr <= addr_step(cur_addr, down);
            cur_cnt  <= cur_cnt - DATA_W'(1);
        end
    end

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !reload && !wr_any) |=> cur_cnt == $past(cur_cnt) - DATA_W'(1));

    assert_reload_base_R5: assert property (@(posedge clk) disable iff (rst)
        (reload && !wr_any) |=> (cur_addr == $past(base_addr)) && (cur_cnt == $past(base_cnt)));

    assert_write_pair_R2: assert property (@(posedge clk) disable iff (rst)
        we_cnt |=> cur_cnt == $past(wdata));
endmodule

// File: rtl/dma_end_ctrl.sv
module dma_end_ctrl
    import dma_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer,
    input  logic [CH_W-1:0]   act_chan,
    input  logic [NUM_CH-1:0] wrap_vec,
    input  logic              eop_in_n,
    input  logic              m2m_en,
    input  logic [NUM_CH-1:0] autoinit_vec,
    input  logic              mask_we,
    input  logic [CH_W-1:0]   mask_chan,
    input  logic              mask_val,
    input  logic              status_rd,
    output logic [NUM_CH-1:0] reload_vec,
    output logic              tc_pulse,
    output logic [NUM_CH-1:0] status_q,
    output logic [NUM_CH-1:0] mask_q
);
    logic tc_int, end_evt, src_side;

    assign src_side = m2m_en && (act_chan == '0);
    assign tc_int   = xfer && wrap_vec[act_chan] && !src_side;
    assign end_evt  = tc_int || (xfer && !eop_in_n);

    always_comb begin
        reload_vec = '0;
        if (end_evt && autoinit_vec[act_chan])
            reload_vec[act_chan] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tc_pulse <= 1'b0;
        else     tc_pulse <= tc_int;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bits
        logic hit;
        assign hit = end_evt && (act_chan == CH_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[i] <= 1'b0;
                mask_q[i]   <= 1'b1;
            end else begin
                if (hit)            status_q[i] <= 1'b1;
                else if (status_rd) status_q[i] <= 1'b0;
                if (hit && !autoinit_vec[i])                 mask_q[i] <= 1'b1;
                else if (mask_we && mask_chan == CH_W'(i))   mask_q[i] <= mask_val;
            end
        end
    end

    assert_pulse_after_xfer_R4: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> $past(xfer));

    assert_end_masks_R6: assert property (@(posedge clk) disable iff (rst)
        (end_evt && !autoinit_vec[act_chan]) |=> mask_q[$past(act_chan)] && status_q[$past(act_chan)]);

    assert_autoinit_keeps_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (end_evt && autoinit_vec[act_chan] && !mask_we) |=> $stable(mask_q));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !end_evt) |=> status_q == '0);
endmodule

// File: rtl/dma_chan_counter.sv
module dma_chan_counter
    import dma_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [CH_W-1:0]   reg_chan,
    input  logic              reg_is_count,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              mode_we,
    input  logic [CH_W-1:0]   mode_chan,
    input  logic              mode_autoinit,
    input  logic              mode_down,
    input  logic              m2m_en,
    input  logic              mask_we,
    input  logic [CH_W-1:0]   mask_chan,
    input  logic              mask_val,
    input  logic              status_rd,
    input  logic              xfer_done,
    input  logic [CH_W-1:0]   act_chan,
    input  logic              eop_in_n,
    output logic [DATA_W-1:0] cur_addr_o,
    output logic [DATA_W-1:0] cur_count_o,
    output logic              tc_pulse_o,
    output logic [NUM_CH-1:0] status_o,
    output logic [NUM_CH-1:0] mask_o
);
    chan_mode_t        mode_q   [NUM_CH];
    logic [DATA_W-1:0] addr_vec [NUM_CH];
    logic [DATA_W-1:0] cnt_vec  [NUM_CH];
    logic [NUM_CH-1:0] wrap_vec, reload_vec, autoinit_vec;
    logic              xfer_eff;

    assign xfer_eff = xfer_done && !(reg_we && reg_chan == act_chan);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_wr, sel_act;
        assign sel_wr  = reg_we && (reg_chan == CH_W'(i));
        assign sel_act = xfer_eff && (act_chan == CH_W'(i));
        assign autoinit_vec[i] = mode_q[i].autoinit;

        always_ff @(posedge clk) begin
            if (rst)                                      mode_q[i] <= MODE_RESET;
            else if (mode_we && mode_chan == CH_W'(i))    mode_q[i] <= '{autoinit: mode_autoinit, down: mode_down};
        end

        dma_chan_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .we_addr  (sel_wr && !reg_is_count),
            .we_cnt   (sel_wr && reg_is_count),
            .wdata    (reg_wdata),
            .step     (sel_act),
            .reload   (reload_vec[i]),
            .down     (mode_q[i].down),
            .cur_addr (addr_vec[i]),
            .cur_cnt  (cnt_vec[i]),
            .wrap     (wrap_vec[i])
        );
    end

    dma_end_ctrl u_end (
        .clk          (clk),
        .rst          (rst),
        .xfer         (xfer_eff),
        .act_chan     (act_chan),
        .wrap_vec     (wrap_vec),
        .eop_in_n     (eop_in_n),
        .m2m_en       (m2m_en),
        .autoinit_vec (autoinit_vec),
        .mask_we      (mask_we),
        .mask_chan    (mask_chan),
        .mask_val     (mask_val),
        .status_rd    (status_rd),
        .reload_vec   (reload_vec),
        .tc_pulse     (tc_pulse_o),
        .status_q     (status_o),
        .mask_q       (mask_o)
    );

    assign cur_addr_o  = addr_vec[act_chan];
    assign cur_count_o = cnt_vec[act_chan];

    assert_m2m_src_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && m2m_en && act_chan == '0) |=> !tc_pulse_o);

    assert_write_cancels_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && xfer_done && reg_chan == act_chan) |=> !tc_pulse_o);
endmodule

// File: tb/dma_chan_counter_tb.sv
module dma_chan_counter_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic reg_we, reg_is_count, mode_we, mode_autoinit, mode_down, m2m_en;
    logic mask_we, mask_val, status_rd, xfer_done, eop_in_n;
    logic [1:0] reg_chan, mode_chan, mask_chan, act_chan;
    logic [15:0] reg_wdata, cur_addr_o, cur_count_o;
    logic tc_pulse_o;
    logic [3:0] status_o, mask_o;

    always #4 clk = ~clk;

    dma_chan_counter dut_i (.*);

    logic [15:0] m_ba[4], m_bc[4], m_ca[4], m_cc[4];
    bit m_auto[4], m_down[4];
    logic [3:0] m_st, m_mask;
    bit exp_pulse;
    int checks = 0, errors = 0;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "cur_addr", cur_addr_o, m_ca[act_chan]);
        chk(tag, "cur_count", cur_count_o, m_cc[act_chan]);
        chk(tag, "tc_pulse", 16'(tc_pulse_o), 16'(exp_pulse));
        chk(tag, "status", 16'(status_o), 16'(m_st));
        chk(tag, "mask", 16'(mask_o), 16'(m_mask));
    endtask

    task automatic apply(string tag);
        @(negedge clk);
        check_all(tag);
        reg_we = 0; mode_we = 0; mask_we = 0; status_rd = 0; xfer_done = 0; eop_in_n = 1;
    endtask

    function automatic logic [15:0] stepa(logic [15:0] a, bit d);
        return d ? a - 16'd1 : a + 16'd1;
    endfunction

    task automatic op_write(int ch, bit is_cnt, logic [15:0] v, bit with_xfer, string tag);
        reg_we = 1; reg_chan = 2'(ch); reg_is_count = is_cnt; reg_wdata = v;
        if (is_cnt) begin m_bc[ch] = v; m_cc[ch] = v; end
        else        begin m_ba[ch] = v; m_ca[ch] = v; end
        if (with_xfer) begin xfer_done = 1; act_chan = 2'(ch); end
        exp_pulse = 0;
        apply(tag);
    endtask

    task automatic op_mode(int ch, bit ai, bit dn, string tag);
        mode_we = 1; mode_chan = 2'(ch); mode_autoinit = ai; mode_down = dn;
        m_auto[ch] = ai; m_down[ch] = dn; exp_pulse = 0;
        apply(tag);
    endtask

    task automatic op_mask(int ch, bit v, string tag);
        mask_we = 1; mask_chan = 2'(ch); mask_val = v;
        m_mask[ch] = v; exp_pulse = 0;
        apply(tag);
    endtask

    task automatic op_xfer(int ch, bit ext, bit rd, bit mwr, bit mv, string tag);
        bit tc, en;
        xfer_done = 1; act_chan = 2'(ch); eop_in_n = !ext; status_rd = rd;
        if (mwr) begin mask_we = 1; mask_chan = 2'(ch); mask_val = mv; m_mask[ch] = mv; end
        tc = (m_cc[ch] == 16'h0) && !(m2m_en && ch == 0);
        en = tc || ext;
        exp_pulse = tc;
        if (en && m_auto[ch]) begin
            m_ca[ch] = m_ba[ch]; m_cc[ch] = m_bc[ch];
        end else begin
            m_ca[ch] = stepa(m_ca[ch], m_down[ch]); m_cc[ch] = m_cc[ch] - 16'd1;
        end
        if (rd) m_st = 4'h0;
        if (en) begin
            m_st[ch] = 1'b1;
            if (!m_auto[ch]) m_mask[ch] = 1'b1;
        end
        apply(tag);
    endtask

    task automatic op_rd(string tag);
        status_rd = 1; m_st = 4'h0; exp_pulse = 0;
        apply(tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        rst = 1; reg_we = 0; reg_is_count = 0; mode_we = 0; mode_autoinit = 0; mode_down = 0;
        m2m_en = 0; mask_we = 0; mask_val = 0; status_rd = 0; xfer_done = 0; eop_in_n = 1;
        reg_chan = 0; mode_chan = 0; mask_chan = 0; act_chan = 0; reg_wdata = 0;
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_auto[i] = 0; m_down[i] = 0;
        end
        m_st = 4'h0; m_mask = 4'hF; exp_pulse = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check_all("R1 reset");

        // R2, R10: program channel 0, unmask it
        op_write(0, 0, 16'h1000, 0, "R2 addr write");
        op_write(0, 1, 16'h0002, 0, "R2 count write");
        op_mask(0, 0, "R10 mask clear");
        // R3, R4, R6: count 2 -> three transfers, last one wraps
        op_xfer(0, 0, 0, 0, 0, "R3 step up");
        op_xfer(0, 0, 0, 0, 0, "R3 step up");
        op_xfer(0, 0, 0, 0, 0, "R4 R6 terminal count");
        op_rd("R9 status read clears");
        // R5: autoinit on channel 1 with count 0
        op_write(1, 0, 16'h2000, 0, "R2 ch1 addr");
        op_write(1, 1, 16'h0000, 0, "R2 ch1 count");
        op_mode(1, 1, 1, "R5 mode write");
        op_mask(1, 0, "R10 unmask ch1");
        op_xfer(1, 0, 0, 0, 0, "R5 autoinit reload");
        op_xfer(1, 0, 1, 0, 0, "R9 read vs set priority");
        // R3 down count, R7 external end
        op_write(2, 0, 16'h0000, 0, "R2 ch2 addr");
        op_write(2, 1, 16'h0010, 0, "R2 ch2 count");
        op_mode(2, 0, 1, "R3 down mode");
        op_xfer(2, 0, 0, 0, 0, "R3 down wrap addr");
        op_xfer(2, 1, 0, 0, 0, "R7 external end");
        // R10: end event beats mask clear
        op_write(3, 1, 16'h0000, 0, "R2 ch3 count");
        op_xfer(3, 0, 0, 1, 0, "R10 end beats mask clear");
        // R11: write cancels transfer
        op_write(3, 1, 16'h0000, 1, "R11 write overrides xfer");
        // R8: memory-to-memory
        m2m_en = 1;
        op_write(0, 1, 16'h0000, 0, "R8 ch0 count");
        op_write(1, 1, 16'h0000, 0, "R8 ch1 count");
        op_mode(1, 0, 0, "R8 ch1 mode");
        op_mask(0, 0, "R8 unmask 0");
        op_xfer(0, 0, 0, 0, 0, "R8 ch0 no pulse");
        op_xfer(1, 0, 0, 0, 0, "R8 ch1 pulses");
        m2m_en = 0;

        for (int n = 0; n < 4000; n++) begin
            int k, ch;
            k = $urandom_range(0, 19);
            ch = $urandom_range(0, 3);
            if (k == 0)      op_write(ch, 0, 16'($urandom), 0, "R2 rnd addr");
            else if (k < 3)  op_write(ch, 1, 16'($urandom_range(0, 3)), $urandom_range(0, 3) == 0, "R11 rnd count");
            else if (k == 3) op_mode(ch, $urandom_range(0, 1), $urandom_range(0, 1), "R3 rnd mode");
            else if (k == 4) op_mask(ch, $urandom_range(0, 1), "R10 rnd mask");
            else if (k == 5) op_rd("R9 rnd read");
            else if (k == 6) m2m_en = $urandom_range(0, 1);
            else op_xfer(ch, $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0,
                         $urandom_range(0, 7) == 0, $urandom_range(0, 1), "R4 R5 R6 R7 R8 rnd xfer");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule